// File: doc/BRIEF.md
# Message FIFO Level Status and Refill Interrupt

This block sits beside the message buffer of a hash engine. It takes the engine's free-running write and read counters and works out how many words are held. From that it raises empty and full flags and packs them, with the engine's idle indication, into one status word for software to read.

It also owns three interrupt sources: hash done, error, and message buffer drained. The drained interrupt is only raised when software could usefully refill the buffer. The buffer must first have filled up completely, and no command may have been issued since then. Otherwise the engine is emptying the buffer faster than software fills it, and an interrupt would only add load.

Each interrupt has a state bit and an enable bit. State bits are cleared by writing 1, and can be forced on through a test write. Each pin is the state bit masked by its enable.

Top module: `msgfifo_irq_gen`

## Requirements
- R1: The held word count is the write count minus the read count, modulo 64. The buffer is empty when the count is 0 and full when it equals 16, including after either counter wraps.
- R2: The status word has idle at bit 0, empty at bit 1, full at bit 2 and the 6-bit held count at bits 9:4. All other bits read 0. It follows the inputs combinationally.
- R3: A full-history flag is set by a clock edge at which the buffer is full. It then holds while the count drops, until an edge at which the buffer is empty or a command rises.
- R4: When a command rises at an edge where the buffer is full, clearing wins and the history flag is not set.
- R5: The drained interrupt condition requires the history flag together with an empty buffer. A buffer that empties without having been full raises nothing.
- R6: The drained condition is registered. Interrupt state bit 1 therefore becomes readable after the second clock edge at which the counts show empty, and not after the first.
- R7: Commands (start, process, stop, continue) act only on their rising edge. A command held high does not stop the history flag from being set again on later full cycles.
- R8: Writing the interrupt state with a mask clears the bits that are 1 in the mask and leaves the others unchanged. The bits are done at 0, drained at 1 and error at 2.
- R9: A test write ORs the written bits into the interrupt state and keeps bits that are already set.
- R10: Interrupt pin i is state bit i AND enable bit i. The enable register is loaded by an enable write and can be read back.
- R11: Done and error event pulses set bits 0 and 2 at the next edge. An event wins over a clear of the same bit in the same cycle.
- R12: Reset clears the interrupt state, the enables, the history flag, the command edge history and the registered drained condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_cnt_i | input | 6 | Words written into the buffer, wrapping |
| rd_cnt_i | input | 6 | Words read out of the buffer, wrapping |
| idle_i | input | 1 | Hash engine idle |
| start_i | input | 1 | Start command level |
| process_i | input | 1 | Process command level |
| stop_i | input | 1 | Stop command level |
| continue_i | input | 1 | Continue command level |
| done_evt_i | input | 1 | Hash done event pulse |
| err_evt_i | input | 1 | Error event pulse |
| state_clr_we_i | input | 1 | Write-1-to-clear strobe for the interrupt state |
| test_we_i | input | 1 | Interrupt test write strobe |
| enable_we_i | input | 1 | Interrupt enable write strobe |
| wdata_i | input | 3 | Write data for the three strobes |
| status_o | output | 32 | Packed status word |
| irq_state_o | output | 3 | Interrupt state bits |
| irq_enable_o | output | 3 | Interrupt enable bits |
| irq_o | output | 3 | Interrupt pins |

## Verification
Two functions can act on the same cycle. The first is the history flag's set-on-full against its clear on a command edge. The bench raises start on a cycle while the buffer is still full, drains the buffer, and expects no drained interrupt. It then holds process high across further full cycles and expects the interrupt once the buffer empties. The second is an event pulse against a write-1-to-clear of the same state bit. The bench drives both in one cycle and expects the bit to read back set.

// File: rtl/msgfifo_irq_pkg.sv
package msgfifo_irq_pkg;

  localparam int unsigned NUM_IRQ = 3;
  localparam int unsigned NUM_CMD = 4;

  localparam int unsigned IRQ_DONE  = 0;
  localparam int unsigned IRQ_EMPTY = 1;
  localparam int unsigned IRQ_ERR   = 2;

  localparam int unsigned ST_IDLE      = 0;
  localparam int unsigned ST_EMPTY     = 1;
  localparam int unsigned ST_FULL      = 2;
  localparam int unsigned ST_DEPTH_LSB = 4;

  typedef struct packed {
    logic cont;
    logic stop;
    logic process;
    logic start;
  } cmd_t;

  // Held words for counters of width w (wrapping subtraction)
  function automatic logic [31:0] held_words(logic [31:0] wr, logic [31:0] rd, int unsigned w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return (wr - rd) & mask;
  endfunction

  // Pack the status word at fixed positions
  function automatic logic [31:0] pack_status(logic idle, logic empty, logic full,
                                              logic [31:0] depth);
    logic [31:0] s;
    s = '0;
    s[ST_IDLE]  = idle;
    s[ST_EMPTY] = empty;
    s[ST_FULL]  = full;
    s = s | (depth << ST_DEPTH_LSB);
    return s;
  endfunction

endpackage

// File: rtl/msgfifo_level.sv
module msgfifo_level #(
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned MAX_DEPTH = 16
) (
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic [CNT_W-1:0] rd_cnt_i,
  output logic [CNT_W-1:0] depth_o,
  output logic             empty_o,
  output logic             full_o
);
  import msgfifo_irq_pkg::*;

  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(MAX_DEPTH);

  logic [31:0] words;

  always_comb begin
    words   = held_words(32'(wr_cnt_i), 32'(rd_cnt_i), CNT_W);
    depth_o = words[CNT_W-1:0];
    empty_o = (depth_o == '0);
    full_o  = (depth_o == FULL_LVL);
  end

endmodule

// File: rtl/msgfifo_cmd_edge.sv
module msgfifo_cmd_edge #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] cmd_i,
  output logic [N-1:0] rise_o,
  output logic         any_rise_o
);

  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= 1'b0;
      else         prev_q[i] <= cmd_i[i];
    end
    assign rise_o[i] = cmd_i[i] & ~prev_q[i];
  end

  assign any_rise_o = |rise_o;

endmodule

// File: rtl/msgfifo_empty_qual.sv
module msgfifo_empty_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic empty_i,
  input  logic full_i,
  input  logic any_rise_i,
  output logic armed_o,
  output logic cond_o
);

  logic armed_q;
  logic cond_q;
  logic clear_w;
  logic cond_d;

  assign clear_w = empty_i | any_rise_i;
  assign cond_d  = armed_q & empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cond_q  <= 1'b0;
    end else begin
      if (clear_w)     armed_q <= 1'b0;
      else if (full_i) armed_q <= 1'b1;
      cond_q <= cond_d;
    end
  end

  assign armed_o = armed_q;
  assign cond_o  = cond_q;

endmodule

// File: rtl/msgfifo_irq_regs.sv
module msgfifo_irq_regs #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] event_i,
  input  logic         clr_we_i,
  input  logic         test_we_i,
  input  logic         en_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] state_o,
  output logic [N-1:0] enable_o,
  output logic [N-1:0] irq_o
);

  logic [N-1:0] state_q;
  logic [N-1:0] enable_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic clr_b;
    logic set_b;
    assign clr_b = clr_we_i & wdata_i[i];
    assign set_b = event_i[i] | (test_we_i & wdata_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        state_q[i]  <= 1'b0;
        enable_q[i] <= 1'b0;
      end else begin
        if (set_b)      state_q[i] <= 1'b1;
        else if (clr_b) state_q[i] <= 1'b0;
        if (en_we_i)    enable_q[i] <= wdata_i[i];
      end
    end

    assign irq_o[i] = state_q[i] & enable_q[i];
  end

  assign state_o  = state_q;
  assign enable_o = enable_q;

endmodule

// File: rtl/msgfifo_irq_gen.sv
module msgfifo_irq_gen #(
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned MAX_DEPTH = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [CNT_W-1:0]                    wr_cnt_i,
  input  logic [CNT_W-1:0]                    rd_cnt_i,
  input  logic                                idle_i,
  input  logic                                start_i,
  input  logic                                process_i,
  input  logic                                stop_i,
  input  logic                                continue_i,
  input  logic                                done_evt_i,
  input  logic                                err_evt_i,
  input  logic                                state_clr_we_i,
  input  logic                                test_we_i,
  input  logic                                enable_we_i,
  input  logic [msgfifo_irq_pkg::NUM_IRQ-1:0] wdata_i,
  output logic [31:0]                         status_o,
  output logic [msgfifo_irq_pkg::NUM_IRQ-1:0] irq_state_o,
  output logic [msgfifo_irq_pkg::NUM_IRQ-1:0] irq_enable_o,
  output logic [msgfifo_irq_pkg::NUM_IRQ-1:0] irq_o
);
  import msgfifo_irq_pkg::*;

  logic [CNT_W-1:0]   depth_w;
  logic               empty_w;
  logic               full_w;
  cmd_t               cmd_w;
  logic [NUM_CMD-1:0] cmd_rise_w;
  logic               any_rise_w;
  logic               armed_w;
  logic               cond_w;
  logic [NUM_IRQ-1:0] events_w;

  msgfifo_level #(.CNT_W(CNT_W), .MAX_DEPTH(MAX_DEPTH)) u_level (
    .wr_cnt_i (wr_cnt_i),
    .rd_cnt_i (rd_cnt_i),
    .depth_o  (depth_w),
    .empty_o  (empty_w),
    .full_o   (full_w)
  );

  assign cmd_w.start   = start_i;
  assign cmd_w.process = process_i;
  assign cmd_w.stop    = stop_i;
  assign cmd_w.cont    = continue_i;

  msgfifo_cmd_edge #(.N(NUM_CMD)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd_w),
    .rise_o     (cmd_rise_w),
    .any_rise_o (any_rise_w)
  );

  msgfifo_empty_qual u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .empty_i    (empty_w),
    .full_i     (full_w),
    .any_rise_i (any_rise_w),
    .armed_o    (armed_w),
    .cond_o     (cond_w)
  );

  always_comb begin
    events_w            = '0;
    events_w[IRQ_DONE]  = done_evt_i;
    events_w[IRQ_EMPTY] = cond_w;
    events_w[IRQ_ERR]   = err_evt_i;
  end

  msgfifo_irq_regs #(.N(NUM_IRQ)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .event_i   (events_w),
    .clr_we_i  (state_clr_we_i),
    .test_we_i (test_we_i),
    .en_we_i   (enable_we_i),
    .wdata_i   (wdata_i),
    .state_o   (irq_state_o),
    .enable_o  (irq_enable_o),
    .irq_o     (irq_o)
  );

  assign status_o = pack_status(idle_i, empty_w, full_w, 32'(depth_w));

endmodule

// File: rtl/msgfifo_irq_gen_chk.sv
module msgfifo_irq_gen_chk #(
  parameter int unsigned N = 3
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         any_rise,
  input logic         empty,
  input logic         armed,
  input logic         cond,
  input logic         test_we,
  input logic         clr_we,
  input logic [N-1:0] wdata,
  input logic         done_evt,
  input logic         err_evt,
  input logic [N-1:0] irq_state,
  input logic [N-1:0] irq_enable,
  input logic [N-1:0] irq
);

  assert_clear_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_rise || empty) |=> !armed);

  assert_cond_needs_arm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond |-> $past(armed && empty));

  assert_empty_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond |=> irq_state[1]);

  assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we && wdata[0] && !done_evt && !test_we) |=> !irq_state[0]);

  assert_test_or_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_we |=> ((irq_state & $past(wdata)) == $past(wdata)));

  assert_pin_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq & ~irq_enable) == '0);

  assert_done_sets_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_evt |=> irq_state[0]);

  assert_err_sets_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt |=> irq_state[N-1]);

endmodule

bind msgfifo_irq_gen msgfifo_irq_gen_chk #(.N(msgfifo_irq_pkg::NUM_IRQ)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .any_rise   (any_rise_w),
  .empty      (empty_w),
  .armed      (armed_w),
  .cond       (cond_w),
  .test_we    (test_we_i),
  .clr_we     (state_clr_we_i),
  .wdata      (wdata_i),
  .done_evt   (done_evt_i),
  .err_evt    (err_evt_i),
  .irq_state  (irq_state_o),
  .irq_enable (irq_enable_o),
  .irq        (irq_o)
);

// File: tb/msgfifo_irq_gen_bench.sv
`timescale 1ns/1ps
module msgfifo_irq_gen_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  wr_cnt_i = '0;
  logic [5:0]  rd_cnt_i = '0;
  logic        idle_i = 1'b0;
  logic        start_i = 1'b0;
  logic        process_i = 1'b0;
  logic        stop_i = 1'b0;
  logic        continue_i = 1'b0;
  logic        done_evt_i = 1'b0;
  logic        err_evt_i = 1'b0;
  logic        state_clr_we_i = 1'b0;
  logic        test_we_i = 1'b0;
  logic        enable_we_i = 1'b0;
  logic [2:0]  wdata_i = '0;
  logic [31:0] status_o;
  logic [2:0]  irq_state_o;
  logic [2:0]  irq_enable_o;
  logic [2:0]  irq_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;

  msgfifo_irq_gen u_msgfifo_irq_gen (.*);

  // {wr, rd, idle, expected status}
  localparam int NV = 8;
  localparam logic [44:0] VEC [NV] = '{
    {6'd0,  6'd0,  1'b1, 32'h003},
    {6'd5,  6'd2,  1'b0, 32'h030},
    {6'd16, 6'd0,  1'b0, 32'h104},
    {6'd2,  6'd50, 1'b1, 32'h105},
    {6'd63, 6'd63, 1'b0, 32'h002},
    {6'd10, 6'd1,  1'b1, 32'h091},
    {6'd0,  6'd63, 1'b0, 32'h010},
    {6'd40, 6'd24, 1'b0, 32'h104}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic counts(logic [5:0] wr, logic [5:0] rd);
    wr_cnt_i = wr;
    rd_cnt_i = rd;
  endtask

  task automatic reg_wr(int kind, logic [2:0] d);
    wdata_i = d;
    state_clr_we_i = (kind == 0);
    test_we_i      = (kind == 1);
    enable_we_i    = (kind == 2);
    tick();
    state_clr_we_i = 1'b0;
    test_we_i = 1'b0;
    enable_we_i = 1'b0;
    wdata_i = '0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    tick(2);
    rst_ni = 1'b1;
    tick();
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick();
    // R12: reset state
    chk("R12 state after reset", 32'(irq_state_o), 0);
    chk("R12 enable after reset", 32'(irq_enable_o), 0);
    do_reset();
    chk("R12 pins after reset", 32'(irq_o), 0);

    // R1 / R2: status table
    for (int v = 0; v < NV; v++) begin
      wr_cnt_i = VEC[v][44:39];
      rd_cnt_i = VEC[v][38:33];
      idle_i   = VEC[v][32];
      #1;
      chk("R1 R2 status vector", status_o, VEC[v][31:0]);
      tick();
    end
    idle_i = 1'b0;
    counts(0, 0);
    do_reset();

    // R3, R6, R10: fill, partial drain, then empty
    reg_wr(2, 3'b111);
    chk("R10 enable readback", 32'(irq_enable_o), 32'h7);
    counts(16, 0); tick();
    counts(16, 8); tick(3);
    counts(16, 16); tick();
    chk("R6 not after first edge", 32'(irq_state_o[1]), 0);
    tick();
    chk("R3 R6 drained irq set", 32'(irq_state_o[1]), 1);
    chk("R10 pin follows enabled state", 32'(irq_o), 32'h2);
    reg_wr(0, 3'b010);
    chk("R8 clear drained bit", 32'(irq_state_o), 0);
    tick(3);
    chk("R5 no refire while empty", 32'(irq_state_o), 0);

    // R5: empty without prior full
    counts(20, 16); tick(2);
    counts(20, 20); tick(3);
    chk("R5 never-full drain silent", 32'(irq_state_o), 0);

    // R4: command rises in a full cycle
    counts(36, 20); start_i = 1'b1; tick();
    start_i = 1'b0; counts(36, 26); tick();
    counts(36, 36); tick(3);
    chk("R4 clear wins over set", 32'(irq_state_o), 0);

    // R3: a command edge after arming disarms
    counts(52, 36); tick(2);
    counts(52, 40); stop_i = 1'b1; tick();
    stop_i = 1'b0; counts(52, 52); tick(3);
    chk("R3 command edge disarms", 32'(irq_state_o), 0);

    // R7: held command re-arms on later full cycles
    counts(4, 52); process_i = 1'b1; tick(3);
    counts(4, 4); tick(2);
    chk("R7 held command no block", 32'(irq_state_o[1]), 1);
    process_i = 1'b0;
    reg_wr(0, 3'b111);

    // R11, R9, R8 on done/err bits
    done_evt_i = 1'b1; tick(); done_evt_i = 1'b0;
    chk("R11 done sets bit0", 32'(irq_state_o), 32'h1);
    reg_wr(1, 3'b100);
    chk("R9 test ORs keep others", 32'(irq_state_o), 32'h5);
    reg_wr(0, 3'b001);
    chk("R8 clear only masked bits", 32'(irq_state_o), 32'h4);
    err_evt_i = 1'b1; done_evt_i = 1'b1; state_clr_we_i = 1'b1; wdata_i = 3'b101;
    tick();
    err_evt_i = 1'b0; done_evt_i = 1'b0; state_clr_we_i = 1'b0; wdata_i = '0;
    chk("R11 event beats clear", 32'(irq_state_o), 32'h5);

    // R10: masking
    reg_wr(2, 3'b010);
    chk("R10 masked pins", 32'(irq_o), 0);
    reg_wr(1, 3'b010);
    chk("R10 test write drives pin", 32'(irq_o), 32'h2);

    // R12: reset clears history mid-run
    counts(20, 4); tick(2);
    rst_ni = 1'b0; tick(); rst_ni = 1'b1;
    chk("R12 state cleared", 32'(irq_state_o), 0);
    counts(20, 20); tick(3);
    chk("R12 history cleared", 32'(irq_state_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule